// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the system-control register updates a processor makes when it takes a synchronous exception, an interrupt or a soft reset. One pulse on `exc_req` carries the exception code, a coprocessor number, the current and next program counters and an entry kind. On the next clock edge the block updates its status, cause, exception-PC and shadow-set registers together. It also presents the handler address for one cycle.

The handler base address, the boot-vector select, the interrupt-vector select, the exception-level flag and the exception shadow set are loaded through a small configuration port. The handler address depends on the boot-vector select, on the exception level as it was before entry, and on the interrupt-vector select. The shadow sets rotate only when entry starts from normal level with boot vectors off.

Top module: `exc_entry_ctl`

## Requirements
- R1: On a non-reset entry with `status[1]` (exception level) and `status[22]` (boot vectors) both 0, `srsctl[9:6]` takes the old `srsctl[3:0]` and `srsctl[3:0]` takes `srsctl[15:12]`. If either flag is 1, `srsctl` does not change.
- R2: Every non-reset entry sets `status[1]` to 1, whether or not it was already set.
- R3: If `nxt_pc` differs from `cur_pc`+4, `epc` becomes `cur_pc`-4 and `cause[31]` is set. Otherwise `epc` becomes `cur_pc` and `cause[31]` is cleared.
- R4: `cause[6:2]` receives `exc_code`. `cause[29:28]` receives `cop_id` when `exc_code` is 0x0B, and is cleared otherwise.
- R5: `kind` values: 0 = general, 1 = TLB refill, 2 = interrupt, 3 = reset. With boot vectors off, a general entry goes to base+0x180.
- R6: A TLB refill entry goes to base+0x000 if the exception level was 0 before entry, and to base+0x180 if it was 1.
- R7: An interrupt entry goes to base+0x200 when `cause[23]` is 1, and to base+0x180 otherwise.
- R8: With `status[22]` set, every non-reset entry goes to 0xBFC00200.
- R9: A reset-kind entry sets `status[29]` (floating-point unit usable) and goes to 0xBFC00000. It leaves `epc`, `cause`, `srsctl` and `status[1]` unchanged.
- R10: All updates appear on the edge after `exc_req` is sampled. `hnd_valid` is high for exactly that one cycle.
- R11: `rst` is synchronous. It gives `status` = 0x00400004 (boot vectors and error level set), clears `cause`, `epc`, `srsctl` and `hnd_valid`, and sets the base to 0x80000000.
- R12: `cfg_we` loads the base, `status[22]`, `status[1]`, `cause[23]` and `srsctl[15:12]`. It is ignored in a cycle where `exc_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Take an exception this cycle |
| exc_code | input | 5 | Exception code |
| cop_id | input | 2 | Coprocessor number for unusable-coprocessor faults |
| cur_pc | input | 32 | PC of the faulting instruction |
| nxt_pc | input | 32 | PC that would follow it |
| kind | input | 2 | Entry kind: 0 general, 1 refill, 2 interrupt, 3 reset |
| cfg_we | input | 1 | Configuration load |
| cfg_ebase | input | 32 | Handler base address |
| cfg_bev | input | 1 | Boot-vector select |
| cfg_exl | input | 1 | Exception-level value |
| cfg_iv | input | 1 | Interrupt-vector select |
| cfg_ess | input | 4 | Exception shadow set |
| status | output | 32 | Status register |
| cause | output | 32 | Cause register |
| epc | output | 32 | Exception PC |
| srsctl | output | 32 | Shadow-set control |
| hnd_pc | output | 32 | Handler address |
| hnd_valid | output | 1 | Handler address valid |

## Verification
The vector table covers each entry kind under both settings of the flag that changes its vector: refill with the prior exception level set and clear, and interrupt with the vector select set and clear. It also covers general entries with the boot vectors on. This separates the base+0x000, +0x180 and +0x200 paths and the fixed boot address. Sequential and branch-shadow PC pairs tell the two exception-PC results apart. Codes 0x0B and 0x0C with a nonzero coprocessor number check that the coprocessor field is filled only for its own code. Directed cases cover the reset kind, the one-cycle valid pulse, configuration that collides with an entry, and the shadow set held steady when rotation is suppressed.

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl #(
  parameter logic [31:0] EBASE_RST = 32'h8000_0000,
  parameter logic [31:0] BOOT_VEC  = 32'hBFC0_0000,
  parameter logic [31:0] BEV_VEC   = 32'hBFC0_0200,
  parameter logic [11:0] GEN_OFS   = 12'h180,
  parameter logic [11:0] INT_OFS   = 12'h200,
  parameter int          INSN_B    = 4,
  parameter logic [4:0]  CPU_CODE  = 5'h0B
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        exc_req,
  input  logic [4:0]  exc_code,
  input  logic [1:0]  cop_id,
  input  logic [31:0] cur_pc,
  input  logic [31:0] nxt_pc,
  input  logic [1:0]  kind,
  input  logic        cfg_we,
  input  logic [31:0] cfg_ebase,
  input  logic        cfg_bev,
  input  logic        cfg_exl,
  input  logic        cfg_iv,
  input  logic [3:0]  cfg_ess,
  output logic [31:0] status,
  output logic [31:0] cause,
  output logic [31:0] epc,
  output logic [31:0] srsctl,
  output logic [31:0] hnd_pc,
  output logic        hnd_valid
);
  localparam logic [31:0] STATUS_RST = 32'h0040_0004;
  localparam logic [31:0] STEP       = 32'(INSN_B);
  localparam logic [1:0]  K_GEN = 2'd0, K_REFILL = 2'd1, K_INT = 2'd2, K_RST = 2'd3;

  logic [31:0] ebase_q, vec_pc;

  wire exl_now = status[1];
  wire bev_now = status[22];
  wire is_rst  = (kind == K_RST);
  wire in_slot = (nxt_pc != cur_pc + STEP);
  wire rotate  = !exl_now && !bev_now;
  wire [1:0] ce_val = (exc_code == CPU_CODE) ? cop_id : 2'd0;

  always_comb begin
    if (is_rst)                vec_pc = BOOT_VEC;
    else if (bev_now)          vec_pc = BEV_VEC;
    else if (kind == K_REFILL) vec_pc = exl_now ? ebase_q + 32'(GEN_OFS) : ebase_q;
    else if (kind == K_INT)    vec_pc = ebase_q + (cause[23] ? 32'(INT_OFS) : 32'(GEN_OFS));
    else                       vec_pc = ebase_q + 32'(GEN_OFS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= STATUS_RST;
      cause     <= '0;
      epc       <= '0;
      srsctl    <= '0;
      ebase_q   <= EBASE_RST;
      hnd_pc    <= '0;
      hnd_valid <= 1'b0;
    end else begin
      hnd_valid <= exc_req;
      if (exc_req) begin
        hnd_pc <= vec_pc;
        if (is_rst) begin
          status[29] <= 1'b1;
        end else begin
          status[1]     <= 1'b1;
          epc           <= in_slot ? cur_pc - STEP : cur_pc;
          cause[31]     <= in_slot;
          cause[29:28]  <= ce_val;
          cause[6:2]    <= exc_code;
          if (rotate) begin
            srsctl[9:6] <= srsctl[3:0];
            srsctl[3:0] <= srsctl[15:12];
          end
        end
      end else if (cfg_we) begin
        ebase_q        <= cfg_ebase;
        status[22]     <= cfg_bev;
        status[1]      <= cfg_exl;
        cause[23]      <= cfg_iv;
        srsctl[15:12]  <= cfg_ess;
      end
    end
  end
endmodule

module exc_entry_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic        exc_req,
  input logic [4:0]  exc_code,
  input logic [1:0]  cop_id,
  input logic [31:0] cur_pc,
  input logic [31:0] nxt_pc,
  input logic [1:0]  kind,
  input logic [31:0] status,
  input logic [31:0] cause,
  input logic [31:0] epc,
  input logic [31:0] srsctl,
  input logic        hnd_valid
);
  wire nr = exc_req && (kind != 2'd3);

  a_r1_rotate: assert property (@(posedge clk) disable iff (rst)
    nr && !status[1] && !status[22] |=> srsctl[9:6] == $past(srsctl[3:0]) && srsctl[3:0] == $past(srsctl[15:12]));
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    nr && (status[1] || status[22]) |=> $stable(srsctl));
  a_r2_exl_set: assert property (@(posedge clk) disable iff (rst)
    nr |=> status[1]);
  a_r3_slot: assert property (@(posedge clk) disable iff (rst)
    nr && (nxt_pc != cur_pc + 32'd4) |=> cause[31] && epc == $past(cur_pc) - 32'd4);
  a_r3_noslot: assert property (@(posedge clk) disable iff (rst)
    nr && (nxt_pc == cur_pc + 32'd4) |=> !cause[31] && epc == $past(cur_pc));
  a_r4_code: assert property (@(posedge clk) disable iff (rst)
    nr |=> cause[6:2] == $past(exc_code));
  a_r9_cu1: assert property (@(posedge clk) disable iff (rst)
    exc_req && kind == 2'd3 |=> status[29] && $stable(epc));
  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    !exc_req |=> !hnd_valid);
  a_r10_valid: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> hnd_valid);
endmodule

bind exc_entry_ctl exc_entry_ctl_chk i_chk (.*);

// File: tb/test_exc_entry_ctl.sv
module test_exc_entry_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EB = 32'h8000_0000;

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  code;
    logic [1:0]  cop;
    logic [31:0] cur;
    logic [31:0] nxt;
    logic        exl;
    logic        bev;
    logic        iv;
    logic [3:0]  ess;
    logic [31:0] exp_pc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 5'h04, 2'd0, 32'h0000_1000, 32'h0000_1004, 1'b0, 1'b0, 1'b0, 4'h3, 32'h8000_0180},
    '{2'd0, 5'h05, 2'd0, 32'h0000_1000, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 4'h5, 32'h8000_0180},
    '{2'd1, 5'h02, 2'd0, 32'h0000_3000, 32'h0000_3004, 1'b0, 1'b0, 1'b0, 4'h7, 32'h8000_0000},
    '{2'd1, 5'h03, 2'd0, 32'h0000_3000, 32'h0000_3004, 1'b1, 1'b0, 1'b0, 4'h9, 32'h8000_0180},
    '{2'd2, 5'h0A, 2'd0, 32'h0000_4000, 32'h0000_4004, 1'b0, 1'b0, 1'b1, 4'hA, 32'h8000_0200},
    '{2'd2, 5'h0A, 2'd0, 32'h0000_4000, 32'h0000_4004, 1'b0, 1'b0, 1'b0, 4'hB, 32'h8000_0180},
    '{2'd0, 5'h0B, 2'd2, 32'h0000_5000, 32'h0000_5004, 1'b0, 1'b0, 1'b0, 4'hC, 32'h8000_0180},
    '{2'd0, 5'h0C, 2'd3, 32'h0000_5000, 32'h0000_6000, 1'b0, 1'b0, 1'b0, 4'hD, 32'h8000_0180},
    '{2'd0, 5'h0C, 2'd1, 32'h0000_7000, 32'h0000_7004, 1'b0, 1'b1, 1'b0, 4'hE, 32'hBFC0_0200}
  };

  logic clk = 0, rst = 1, exc_req = 0, cfg_we = 0;
  logic [4:0] exc_code = 0;
  logic [1:0] cop_id = 0, kind = 0;
  logic [31:0] cur_pc = 0, nxt_pc = 0, cfg_ebase = EB;
  logic cfg_bev = 0, cfg_exl = 0, cfg_iv = 0;
  logic [3:0] cfg_ess = 0;
  logic [31:0] status, cause, epc, srsctl, hnd_pc;
  logic hnd_valid;
  int checks = 0, fails = 0;
  logic [3:0] m_css = 0, m_pss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctl i_exc_entry_ctl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic bev, input logic exl, input logic iv, input logic [3:0] ess);
    @(negedge clk);
    cfg_we = 1; cfg_ebase = EB; cfg_bev = bev; cfg_exl = exl; cfg_iv = iv; cfg_ess = ess;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 status", status, 32'h0040_0004);
    chk("R11 cause", cause, 0);
    chk("R11 epc", epc, 0);
    chk("R11 srsctl", srsctl, 0);
    chk("R11 valid", {31'd0, hnd_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] e_epc, e_srs;
      logic rot;
      cfg(TBL[i].bev, TBL[i].exl, TBL[i].iv, TBL[i].ess);
      rot = !TBL[i].exl && !TBL[i].bev;
      if (rot) begin m_pss = m_css; m_css = TBL[i].ess; end
      e_srs = {16'd0, TBL[i].ess, 2'd0, m_pss, 2'd0, m_css};
      e_epc = (TBL[i].nxt != TBL[i].cur + 4) ? TBL[i].cur - 4 : TBL[i].cur;
      exc_req = 1; kind = TBL[i].kind; exc_code = TBL[i].code;
      cop_id = TBL[i].cop; cur_pc = TBL[i].cur; nxt_pc = TBL[i].nxt;
      @(negedge clk);
      exc_req = 0;
      chk("R5/R6/R7/R8 handler pc", hnd_pc, TBL[i].exp_pc);
      chk("R10 valid", {31'd0, hnd_valid}, 1);
      chk("R3 epc", epc, e_epc);
      chk("R3 bd", {31'd0, cause[31]}, {31'd0, TBL[i].nxt != TBL[i].cur + 4});
      chk("R4 code", {27'd0, cause[6:2]}, {27'd0, TBL[i].code});
      chk("R4 ce", {30'd0, cause[29:28]}, {30'd0, (TBL[i].code == 5'h0B) ? TBL[i].cop : 2'd0});
      chk("R2 exl", {31'd0, status[1]}, 1);
      chk("R1 srsctl", srsctl, e_srs);
      @(negedge clk);
      chk("R10 one cycle", {31'd0, hnd_valid}, 0);
    end

    // R9 reset kind
    begin
      logic [31:0] ep, ca, sr;
      cfg(1'b0, 1'b0, 1'b0, 4'h6);
      ep = epc; ca = cause; sr = srsctl;
      exc_req = 1; kind = 2'd3; exc_code = 5'h07; cur_pc = 32'h9000; nxt_pc = 32'hA000;
      @(negedge clk);
      exc_req = 0;
      chk("R9 pc", hnd_pc, 32'hBFC0_0000);
      chk("R9 cu1", {31'd0, status[29]}, 1);
      chk("R9 exl kept", {31'd0, status[1]}, 0);
      chk("R9 epc kept", epc, ep);
      chk("R9 cause kept", cause, ca);
      chk("R9 srsctl kept", srsctl, sr);
    end

    // R12 config ignored during entry
    cfg(1'b0, 1'b0, 1'b0, 4'h1);
    exc_req = 1; kind = 2'd0; exc_code = 5'h04; cur_pc = 32'h100; nxt_pc = 32'h104;
    cfg_we = 1; cfg_bev = 1; cfg_exl = 0; cfg_iv = 1; cfg_ess = 4'hF; cfg_ebase = 32'h1234_0000;
    @(negedge clk);
    exc_req = 0; cfg_we = 0;
    chk("R12 bev ignored", {31'd0, status[22]}, 0);
    chk("R12 iv ignored", {31'd0, cause[23]}, 0);
    chk("R12 ess ignored", {28'd0, srsctl[15:12]}, 4'h1);
    chk("R12 exl from entry", {31'd0, status[1]}, 1);
    // R12 base unchanged: next general entry with bev off
    cfg_we = 0;
    exc_req = 1; kind = 2'd0;
    @(negedge clk);
    exc_req = 0;
    chk("R12 base ignored", hnd_pc, 32'h8000_0180);

    // R11 reset mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R11 status again", status, 32'h0040_0004);
    chk("R11 srsctl again", srsctl, 0);
    chk("R11 epc again", epc, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule